// File: doc/BRIEF.md
# Dual-Slot Instruction Dispatch Unit

This block sits at the end of the decode stage. It looks at the two oldest entries of an in-order instruction queue and moves up to two of them per cycle into the issue queues and the completion queue. Branch-class work goes to a branch issue queue. Integer, multiply and load/store work goes to a general issue queue. Synchronisation, return-from-interrupt, system-call and no-op classes get a completion-queue entry but are not written to any issue queue. Every dispatched instruction receives the next completion-queue tag, counted modulo the completion-queue depth.

The dispatch decision is combinational, so the instruction queue can shift by the reported count at the same clock edge. The writes into the queues are registered and reach the queue ports one cycle later. The free-space counts that the queues report do not yet include those writes in flight. The block therefore subtracts its own pending writes from each count before it decides.

Top module: `dispatch_unit`

## Requirements
- R1: The class code selects the destination. Codes 0 (integer), 1 (multiply) and 2 (load/store) go to the general queue. Code 3 (branch) goes to the branch queue. Codes 4 to 7 (sync, return-from-interrupt, system call, no-op) go to no issue queue.
- R2: Only slot 0 and slot 1 are candidates in a cycle. `iq_pop` gives the number dispatched (0, 1 or 2) in the same cycle as the inputs that caused it.
- R3: The branch queue receives at most one instruction per cycle, even when both slots hold branches.
- R4: The general queue receives up to two instructions per cycle. The older general-queue instruction always uses lane 0, and lane 1 is used only when lane 0 is used.
- R5: Dispatch is in order. If slot 0 does not dispatch, slot 1 does not dispatch either.
- R6: An instruction dispatches only when a completion-queue entry is free for it, counting the entry that slot 0 takes in the same cycle.
- R7: Classes with no issue-queue destination raise a completion-queue write and no issue-queue write.
- R8: Queue writes appear on the outputs one cycle after the decision. Reset clears every write enable.
- R9: Each free-space count is reduced by the block's own writes still in the output register. No queue ever receives more entries than it has free.
- R10: Completion tags are consecutive modulo the completion-queue depth (default 14) and start at 0 after reset. Slot 0 gets the lower tag.
- R11: Slot 1 is checked against issue-queue space after subtracting the entry slot 0 takes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iq_vld | input | 2 | Valid bits of slot 0 (bit 0) and slot 1 (bit 1) |
| iq_cls0 | input | 3 | Class code of slot 0 |
| iq_cls1 | input | 3 | Class code of slot 1 |
| iq_ins0 | input | INS_W | Payload of slot 0 |
| iq_ins1 | input | INS_W | Payload of slot 1 |
| brq_free | input | CNT_W | Free entries reported by the branch queue |
| gpq_free | input | CNT_W | Free entries reported by the general queue |
| cq_free | input | CNT_W | Free entries reported by the completion queue |
| iq_pop | output | 2 | Number of slots dispatched this cycle |
| brq_we | output | 1 | Branch queue write enable |
| brq_ins | output | INS_W | Branch queue write payload |
| brq_tag | output | TAG_W | Completion tag of the branch write |
| gpq_we | output | 2 | General queue lane write enables |
| gpq_ins0 | output | INS_W | General queue lane 0 payload |
| gpq_ins1 | output | INS_W | General queue lane 1 payload |
| gpq_tag0 | output | TAG_W | Completion tag on lane 0 |
| gpq_tag1 | output | TAG_W | Completion tag on lane 1 |
| cq_we | output | 2 | Completion queue allocation enables, one per dispatched slot |
| cq_tag0 | output | TAG_W | Tag allocated for the first dispatched slot |
| cq_tag1 | output | TAG_W | Tag allocated for the second dispatched slot |

## Verification
A wrong tail pointer shows at once as a tag gap on the next allocation. A routing or lane-packing error shows one cycle after the decision, on the write enables and payloads. A lost or doubled pending-write credit does not show at once. It shows a few cycles later, when a queue with no drain is filled, as one entry too many written or `iq_pop` held low while space remains. The bench therefore runs long streams against small modelled queues and tracks their occupancy every cycle.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [2:0] {
    CL_ALU  = 3'd0,
    CL_MUL  = 3'd1,
    CL_LSU  = 3'd2,
    CL_BR   = 3'd3,
    CL_SYNC = 3'd4,
    CL_RFI  = 3'd5,
    CL_SC   = 3'd6,
    CL_NOP  = 3'd7
  } iclass_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_BRQ  = 2'd1,
    DST_GPQ  = 2'd2
  } dest_e;

  function automatic logic [1:0] dest_of(input logic [2:0] c);
    logic [1:0] d;
    case (c)
      CL_ALU, CL_MUL, CL_LSU: d = DST_GPQ;
      CL_BR:                  d = DST_BRQ;
      default:                d = DST_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dsp_route.sv
module dsp_route
  import dsp_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic [SLOTS-1:0][2:0] cls_i,
  output logic [SLOTS-1:0][1:0] dst_o
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign dst_o[s] = dest_of(cls_i[s]);
  end

endmodule

// File: rtl/dsp_credit.sv
module dsp_credit #(
  parameter int CNT_W  = 5,
  parameter int PEND_W = 2
) (
  input  logic [CNT_W-1:0]  free_i,
  input  logic [PEND_W-1:0] pend_i,
  output logic [CNT_W-1:0]  eff_o
);

  logic [CNT_W-1:0] pend_ext;

  assign pend_ext = CNT_W'(pend_i);
  assign eff_o    = (free_i > pend_ext) ? (free_i - pend_ext) : '0;

endmodule

// File: rtl/dsp_pick.sv
module dsp_pick
  import dsp_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int BRQ_CAP = 1,
  parameter int GPQ_CAP = 2
) (
  input  logic [1:0]       vld_i,
  input  logic [1:0]       dst0_i,
  input  logic [1:0]       dst1_i,
  input  logic [CNT_W-1:0] brq_eff_i,
  input  logic [CNT_W-1:0] gpq_eff_i,
  input  logic [CNT_W-1:0] cq_eff_i,
  output logic [1:0]       go_o,
  output logic [1:0]       pop_o
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] BCAP = CNT_W'(BRQ_CAP);
  localparam logic [CNT_W-1:0] GCAP = CNT_W'(GPQ_CAP);

  logic             s0_brq, s0_gpq, s1_brq, s1_gpq;
  logic [CNT_W-1:0] b_used, g_used;
  logic             ok0, ok1;

  assign s0_brq = (dst0_i == DST_BRQ);
  assign s0_gpq = (dst0_i == DST_GPQ);
  assign s1_brq = (dst1_i == DST_BRQ);
  assign s1_gpq = (dst1_i == DST_GPQ);

  // entries that slot 0 takes from each issue queue this cycle
  assign b_used = s0_brq ? ONE : '0;
  assign g_used = s0_gpq ? ONE : '0;

  always_comb begin
    ok0 = vld_i[0] && (cq_eff_i >= ONE)
        && (!s0_brq || (brq_eff_i >= ONE && BCAP >= ONE))
        && (!s0_gpq || (gpq_eff_i >= ONE && GCAP >= ONE));
    ok1 = ok0 && vld_i[1] && (cq_eff_i >= TWO)
        && (!s1_brq || ((b_used + ONE) <= BCAP && brq_eff_i >= (b_used + ONE)))
        && (!s1_gpq || ((g_used + ONE) <= GCAP && gpq_eff_i >= (g_used + ONE)));
  end

  assign go_o  = {ok1, ok0};
  assign pop_o = {ok1, ok0 ^ ok1};

endmodule

// File: rtl/dispatch_unit.sv
module dispatch_unit
  import dsp_pkg::*;
#(
  parameter int INS_W    = 32,
  parameter int CNT_W    = 5,
  parameter int CQ_DEPTH = 14,
  parameter int BRQ_CAP  = 1,
  parameter int GPQ_CAP  = 2,
  localparam int TAG_W   = $clog2(CQ_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       iq_vld,
  input  logic [2:0]       iq_cls0,
  input  logic [2:0]       iq_cls1,
  input  logic [INS_W-1:0] iq_ins0,
  input  logic [INS_W-1:0] iq_ins1,
  input  logic [CNT_W-1:0] brq_free,
  input  logic [CNT_W-1:0] gpq_free,
  input  logic [CNT_W-1:0] cq_free,
  output logic [1:0]       iq_pop,
  output logic             brq_we,
  output logic [INS_W-1:0] brq_ins,
  output logic [TAG_W-1:0] brq_tag,
  output logic [1:0]       gpq_we,
  output logic [INS_W-1:0] gpq_ins0,
  output logic [INS_W-1:0] gpq_ins1,
  output logic [TAG_W-1:0] gpq_tag0,
  output logic [TAG_W-1:0] gpq_tag1,
  output logic [1:0]       cq_we,
  output logic [TAG_W-1:0] cq_tag0,
  output logic [TAG_W-1:0] cq_tag1
);

  localparam logic [TAG_W-1:0] TAG_LAST = TAG_W'(CQ_DEPTH - 1);

  function automatic logic [TAG_W-1:0] tag_inc(input logic [TAG_W-1:0] t);
    return (t == TAG_LAST) ? '0 : t + TAG_W'(1);
  endfunction

  // ---------------- routing ----------------
  logic [1:0][1:0] dst;

  dsp_route #(.SLOTS(2)) u_route (
    .cls_i ({iq_cls1, iq_cls0}),
    .dst_o (dst)
  );

  // ---------------- credit for writes still in the output register ----------------
  logic [1:0]       brq_pend, gpq_pend, cq_pend;
  logic [CNT_W-1:0] brq_eff, gpq_eff, cq_eff;

  assign brq_pend = {1'b0, brq_we};
  assign gpq_pend = {gpq_we[1] & gpq_we[0], gpq_we[1] ^ gpq_we[0]};
  assign cq_pend  = {cq_we[1] & cq_we[0], cq_we[1] ^ cq_we[0]};

  dsp_credit #(.CNT_W(CNT_W), .PEND_W(2)) u_crd_brq (
    .free_i (brq_free), .pend_i (brq_pend), .eff_o (brq_eff));
  dsp_credit #(.CNT_W(CNT_W), .PEND_W(2)) u_crd_gpq (
    .free_i (gpq_free), .pend_i (gpq_pend), .eff_o (gpq_eff));
  dsp_credit #(.CNT_W(CNT_W), .PEND_W(2)) u_crd_cq (
    .free_i (cq_free),  .pend_i (cq_pend),  .eff_o (cq_eff));

  // ---------------- slot selection ----------------
  logic [1:0] go;

  dsp_pick #(.CNT_W(CNT_W), .BRQ_CAP(BRQ_CAP), .GPQ_CAP(GPQ_CAP)) u_pick (
    .vld_i     (iq_vld),
    .dst0_i    (dst[0]),
    .dst1_i    (dst[1]),
    .brq_eff_i (brq_eff),
    .gpq_eff_i (gpq_eff),
    .cq_eff_i  (cq_eff),
    .go_o      (go),
    .pop_o     (iq_pop)
  );

  // ---------------- completion tags ----------------
  logic [TAG_W-1:0] tail, tag0, tag1;

  assign tag0 = tail;
  assign tag1 = tag_inc(tail);

  always_ff @(posedge clk) begin
    if (rst)        tail <= '0;
    else if (go[1]) tail <= tag_inc(tag1);
    else if (go[0]) tail <= tag1;
  end

  // ---------------- lane packing ----------------
  logic             s0b, s1b, s0g, s1g;
  logic             nb_we;
  logic [1:0]       ng_we;
  logic [INS_W-1:0] nb_ins, ng_ins0;
  logic [TAG_W-1:0] nb_tag, ng_tag0;

  always_comb begin
    s0b     = go[0] && (dst[0] == DST_BRQ);
    s1b     = go[1] && (dst[1] == DST_BRQ);
    s0g     = go[0] && (dst[0] == DST_GPQ);
    s1g     = go[1] && (dst[1] == DST_GPQ);
    nb_we   = s0b | s1b;
    nb_ins  = s0b ? iq_ins0 : iq_ins1;
    nb_tag  = s0b ? tag0 : tag1;
    ng_we   = {s0g & s1g, s0g | s1g};
    ng_ins0 = s0g ? iq_ins0 : iq_ins1;
    ng_tag0 = s0g ? tag0 : tag1;
  end

  // ---------------- registered queue writes ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      brq_we <= 1'b0;
      gpq_we <= 2'b00;
      cq_we  <= 2'b00;
    end else begin
      brq_we <= nb_we;
      gpq_we <= ng_we;
      cq_we  <= go;
    end
  end

  always_ff @(posedge clk) begin
    brq_ins  <= nb_ins;
    brq_tag  <= nb_tag;
    gpq_ins0 <= ng_ins0;
    gpq_tag0 <= ng_tag0;
    gpq_ins1 <= iq_ins1;
    gpq_tag1 <= tag1;
    cq_tag0  <= tag0;
    cq_tag1  <= tag1;
  end

  // ---------------- assertions ----------------
  int unsigned chk_next;

  always_ff @(posedge clk) begin
    if (rst) chk_next <= 0;
    else     chk_next <= (chk_next + $countones(cq_we)) % CQ_DEPTH;
  end

  // R5
  in_order_chk: assert property (@(posedge clk) disable iff (rst)
    cq_we[1] |-> cq_we[0]);

  // R7
  issue_le_cq_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(gpq_we) + $countones(brq_we)) <= $countones(cq_we));

  // R4
  lane_pack_chk: assert property (@(posedge clk) disable iff (rst)
    gpq_we[1] |-> gpq_we[0]);

  // R9
  gpq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gpq_we) <= int'(gpq_free));

  // R9
  brq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(brq_we) <= int'(brq_free));

  // R6
  cq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(cq_we) <= int'(cq_free));

  // R10
  tag_seq_chk: assert property (@(posedge clk) disable iff (rst)
    cq_we[0] |-> (int'(cq_tag0) == int'(chk_next)));

  // R8
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cq_we == 2'b00 && gpq_we == 2'b00 && !brq_we));

endmodule

// File: tb/dispatch_unit_tb.sv
module dispatch_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int INS_W = 32;
  localparam int CNT_W = 5;
  localparam int CQ_D  = 14;
  localparam int BQ_D  = 4;
  localparam int GQ_D  = 6;
  localparam int TAG_W = $clog2(CQ_D);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       iq_vld = '0;
  logic [2:0]       iq_cls0 = '0, iq_cls1 = '0;
  logic [INS_W-1:0] iq_ins0 = '0, iq_ins1 = '0;
  logic [CNT_W-1:0] brq_free = '0, gpq_free = '0, cq_free = '0;
  logic [1:0]       iq_pop;
  logic             brq_we;
  logic [INS_W-1:0] brq_ins, gpq_ins0, gpq_ins1;
  logic [TAG_W-1:0] brq_tag, gpq_tag0, gpq_tag1, cq_tag0, cq_tag1;
  logic [1:0]       gpq_we, cq_we;

  dispatch_unit #(.INS_W(INS_W), .CNT_W(CNT_W), .CQ_DEPTH(CQ_D)) u_dut (
    .clk, .rst, .iq_vld, .iq_cls0, .iq_cls1, .iq_ins0, .iq_ins1,
    .brq_free, .gpq_free, .cq_free, .iq_pop,
    .brq_we, .brq_ins, .brq_tag, .gpq_we, .gpq_ins0, .gpq_ins1,
    .gpq_tag0, .gpq_tag1, .cq_we, .cq_tag0, .cq_tag1);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // bench model of the instruction queue and the three target queues
  int          q_cls [64];
  logic [31:0] q_ins [64];
  int q_len, head, tag, last_pop;
  int occ_b, occ_g, occ_c, drn_b, drn_g, drn_c, pend_b, pend_g, pend_c;
  int e_bwe, e_btag, e_gwe, e_gtag0, e_gtag1, e_cwe, e_ctag0, e_ctag1;
  logic [31:0] e_bins, e_gins0, e_gins1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // R1 class encoding: 0..2 general (2), 3 branch (1), 4..7 none (0)
  function automatic int dst_of(input int c);
    if (c <= 2) return 2;
    if (c == 3) return 1;
    return 0;
  endfunction

  function automatic int sat(input int v);
    return (v < 0) ? 0 : v;
  endfunction

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic push(input int c, input logic [31:0] ins);
    q_cls[q_len] = c;
    q_ins[q_len] = ins;
    q_len++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    iq_vld = '0;
    brq_free = CNT_W'(BQ_D); gpq_free = CNT_W'(GQ_D); cq_free = CNT_W'(CQ_D);
    q_len = 0; head = 0; tag = 0; last_pop = 0;
    occ_b = 0; occ_g = 0; occ_c = 0; drn_b = 0; drn_g = 0; drn_c = 0;
    pend_b = 0; pend_g = 0; pend_c = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!brq_we && gpq_we == 0 && cq_we == 0, "R8 reset clears writes",
        {brq_we, gpq_we, cq_we}, 0);
  endtask

  // one cycle: starts and ends at a falling edge
  task automatic step();
    bit v0, v1, go0, go1;
    int d0, d1, eb, eg, ec, ep, t0, t1;
    v0 = head < q_len;
    v1 = (head + 1) < q_len;
    iq_vld  = {v1, v0};
    iq_cls0 = v0 ? 3'(q_cls[head]) : 3'd0;
    iq_cls1 = v1 ? 3'(q_cls[head+1]) : 3'd0;
    iq_ins0 = v0 ? q_ins[head] : '0;
    iq_ins1 = v1 ? q_ins[head+1] : '0;
    brq_free = CNT_W'(BQ_D - occ_b);
    gpq_free = CNT_W'(GQ_D - occ_g);
    cq_free  = CNT_W'(CQ_D - occ_c);
    #1;
    d0 = v0 ? dst_of(q_cls[head]) : 0;
    d1 = v1 ? dst_of(q_cls[head+1]) : 0;
    eb = sat(BQ_D - occ_b - pend_b);
    eg = sat(GQ_D - occ_g - pend_g);
    ec = sat(CQ_D - occ_c - pend_c);
    go0 = v0 && ec >= 1 && (d0 != 1 || eb >= 1) && (d0 != 2 || eg >= 1);
    go1 = go0 && v1 && ec >= 2 && (d1 != 1 || (d0 != 1 && eb >= 1))
          && (d1 != 2 || eg >= 1 + ((d0 == 2) ? 1 : 0));
    ep = int'(go0) + int'(go1);
    last_pop = int'(iq_pop);
    chk(int'(iq_pop) == ep, "R2 R5 R6 R11 pop count", iq_pop, ep);
    t0 = tag;
    t1 = (tag + 1) % CQ_D;
    e_bwe = 0; e_gwe = 0;
    e_bins = '0; e_btag = 0; e_gins0 = '0; e_gtag0 = 0; e_gins1 = '0; e_gtag1 = 0;
    if (go0 && d0 == 1) begin e_bwe = 1; e_bins = q_ins[head]; e_btag = t0; end
    else if (go1 && d1 == 1) begin e_bwe = 1; e_bins = q_ins[head+1]; e_btag = t1; end
    if (go0 && d0 == 2) begin
      e_gwe = 1; e_gins0 = q_ins[head]; e_gtag0 = t0;
      if (go1 && d1 == 2) begin e_gwe = 3; e_gins1 = q_ins[head+1]; e_gtag1 = t1; end
    end else if (go1 && d1 == 2) begin
      e_gwe = 1; e_gins0 = q_ins[head+1]; e_gtag0 = t1;
    end
    e_cwe = go1 ? 3 : (go0 ? 1 : 0);
    e_ctag0 = t0; e_ctag1 = t1;
    @(posedge clk);
    occ_b = occ_b - mn(drn_b, occ_b) + pend_b;
    occ_g = occ_g - mn(drn_g, occ_g) + pend_g;
    occ_c = occ_c - mn(drn_c, occ_c) + pend_c;
    pend_b = e_bwe;
    pend_g = (e_gwe == 3) ? 2 : e_gwe;
    pend_c = ep;
    head += ep;
    tag = (tag + ep) % CQ_D;
    @(negedge clk);
    chk(occ_b <= BQ_D && occ_g <= GQ_D && occ_c <= CQ_D, "R9 no queue overfill",
        occ_b * 10000 + occ_g * 100 + occ_c, 0);
    chk(int'(brq_we) == e_bwe, "R3 R8 branch write", brq_we, e_bwe);
    if (e_bwe != 0)
      chk(brq_ins == e_bins && int'(brq_tag) == e_btag, "R1 R10 branch payload/tag",
          brq_ins, e_bins);
    chk(int'(gpq_we) == e_gwe, "R4 R7 general lanes", gpq_we, e_gwe);
    if (e_gwe != 0)
      chk(gpq_ins0 == e_gins0 && int'(gpq_tag0) == e_gtag0, "R4 lane0 payload/tag",
          gpq_ins0, e_gins0);
    if (e_gwe == 3)
      chk(gpq_ins1 == e_gins1 && int'(gpq_tag1) == e_gtag1, "R4 lane1 payload/tag",
          gpq_ins1, e_gins1);
    chk(int'(cq_we) == e_cwe, "R6 R8 completion allocation", cq_we, e_cwe);
    if (e_cwe != 0)
      chk(int'(cq_tag0) == e_ctag0, "R10 first tag", cq_tag0, e_ctag0);
    if (e_cwe == 3)
      chk(int'(cq_tag1) == e_ctag1, "R10 second tag", cq_tag1, e_ctag1);
  endtask

  task automatic t_reset();
    do_reset();
    step();
    chk(last_pop == 0, "R2 empty queue pops nothing", last_pop, 0);
  endtask

  task automatic t_pair_general();
    do_reset();
    push(0, 32'hA1); push(1, 32'hA2);
    step();
    chk(last_pop == 2, "R2 two general dispatch", last_pop, 2);
    chk(gpq_we == 2'b11 && gpq_ins0 == 32'hA1 && gpq_ins1 == 32'hA2,
        "R4 in-order lanes", gpq_ins0, 32'hA1);
    chk(cq_tag0 == 0 && cq_tag1 == 1, "R10 tags from reset", cq_tag1, 1);
  endtask

  task automatic t_branch_pair();
    do_reset();
    push(3, 32'hB1); push(3, 32'hB2); push(3, 32'hB3);
    step();
    chk(last_pop == 1, "R3 one branch per cycle", last_pop, 1);
    step();
    chk(last_pop == 1, "R3 second branch alone", last_pop, 1);
    chk(brq_we && brq_ins == 32'hB2 && brq_tag == 1, "R3 branch payload", brq_ins, 32'hB2);
  endtask

  task automatic t_blocked_head();
    do_reset();
    occ_b = BQ_D;
    push(3, 32'hC1); push(0, 32'hC2);
    repeat (3) step();
    chk(head == 0, "R5 slot1 waits behind blocked slot0", head, 0);
    chk(gpq_we == 2'b00, "R5 no general write", gpq_we, 0);
  endtask

  task automatic t_cq_only();
    do_reset();
    push(4, 32'hD1); push(5, 32'hD2); push(6, 32'hD3); push(7, 32'hD4);
    step();
    chk(last_pop == 2, "R7 cq-only pair dispatches", last_pop, 2);
    chk(!brq_we && gpq_we == 0 && cq_we == 2'b11, "R7 no issue write",
        {brq_we, gpq_we}, 0);
    step();
    chk(last_pop == 2, "R7 second cq-only pair", last_pop, 2);
  endtask

  task automatic t_cq_space();
    do_reset();
    occ_c = CQ_D - 1;
    push(0, 32'hE1); push(0, 32'hE2);
    step();
    chk(last_pop == 1, "R6 one free cq entry", last_pop, 1);
    step();
    chk(last_pop == 0, "R6 cq full after pending write", last_pop, 0);
  endtask

  task automatic t_gpq_space();
    do_reset();
    occ_g = GQ_D - 1;
    push(0, 32'hF1); push(2, 32'hF2);
    step();
    chk(last_pop == 1, "R11 slot0 used last general entry", last_pop, 1);
    do_reset();
    occ_g = GQ_D - 1;
    push(3, 32'hF3); push(2, 32'hF4);
    step();
    chk(last_pop == 2, "R11 branch in slot0 leaves general entry", last_pop, 2);
  endtask

  task automatic t_mixed_lanes();
    do_reset();
    push(3, 32'h51); push(2, 32'h52);
    step();
    chk(last_pop == 2, "R1 branch plus load/store", last_pop, 2);
    chk(brq_we && brq_ins == 32'h51 && gpq_we == 2'b01 && gpq_ins0 == 32'h52
        && gpq_tag0 == 1, "R4 R1 older general uses lane0", gpq_ins0, 32'h52);
  endtask

  task automatic t_credit();
    do_reset();
    for (int i = 0; i < 10; i++) push(0, 32'h600 + i);
    repeat (8) step();
    chk(head == GQ_D, "R9 exactly the free entries written", head, GQ_D);
    chk(occ_g == GQ_D, "R9 general queue full, not over", occ_g, GQ_D);
  endtask

  task automatic t_wrap();
    do_reset();
    drn_b = 2; drn_g = 2; drn_c = 2;
    for (int i = 0; i < 20; i++) push(1, 32'h700 + i);
    repeat (10) step();
    chk(head == 20, "R2 sustained two per cycle", head, 20);
    chk(cq_tag0 == 4 && cq_tag1 == 5, "R10 tags wrap modulo depth", cq_tag0, 4);
  endtask

  task automatic t_stream();
    do_reset();
    drn_b = 1; drn_g = 1; drn_c = 1;
    for (int i = 0; i < 40; i++) push((i * 5 + 3) % 8, 32'h800 + i);
    for (int k = 0; k < 150 && head < q_len; k++) step();
    repeat (2) step();
    chk(head == q_len, "R2 mixed stream drains", head, q_len);
  endtask

  initial begin
    t_reset();
    t_pair_general();
    t_branch_pair();
    t_blocked_head();
    t_cq_only();
    t_cq_space();
    t_gpq_space();
    t_mixed_lanes();
    t_credit();
    t_wrap();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule